// File: doc/BRIEF.md
# Mailbox Interrupt Controller

This block raises port-to-port interrupts for a two-port shared memory. It watches each port's select, write strobe, output enable and word address. The top two word addresses serve as mailboxes. The highest address belongs to the right port, and the address one below it belongs to the left port. When a port writes into the other side's mailbox, the block raises that side's interrupt. The owner drops its interrupt by reading its own mailbox. The message words themselves live in the memory array, and this block only decodes the accesses.

Each port also has a busy input, driven by the arbiter that resolves address collisions. While a port's busy is high, that port can neither raise the other side's interrupt nor clear its own. Both interrupt outputs are active low and registered. An access seen at one clock edge is visible on the outputs just after that edge.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, both `l_irq_n` and `r_irq_n` are 1.
- R2: A left write (`l_sel`=1, `l_wr`=1, `l_busy`=0) to address 2^AW-1 drives `r_irq_n` to 0 after the next clock edge.
- R3: A right write (`r_sel`=1, `r_wr`=1, `r_busy`=0) to address 2^AW-2 drives `l_irq_n` to 0 after the next clock edge.
- R4: An owner read returns that owner's interrupt to 1 after the edge. An owner read is `sel`=1, `wr`=0, `oe`=1 and `busy`=0. For the right port the address is 2^AW-1, and for the left port it is 2^AW-2. A read with `oe`=0 does not clear the interrupt.
- R5: When a port reads the other port's mailbox, the other port's interrupt does not change.
- R6: If the writing port's busy is 1, its write to the other mailbox does not raise the interrupt.
- R7: If the owner's busy is 1, its read of its own mailbox does not clear its interrupt.
- R8: If a raise and a clear of the same interrupt happen in the same cycle, the interrupt ends up asserted (0).
- R9: An access with `sel`=0 has no effect on either interrupt.
- R10: A write to any other address, or a port writing its own mailbox, raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_sel | input | 1 | Left port select, active high |
| l_wr | input | 1 | Left write strobe, 1 = write |
| l_oe | input | 1 | Left output enable, active high |
| l_addr | input | AW | Left word address |
| l_busy | input | 1 | Left busy from the arbiter |
| r_sel | input | 1 | Right port select, active high |
| r_wr | input | 1 | Right write strobe, 1 = write |
| r_oe | input | 1 | Right output enable, active high |
| r_addr | input | AW | Right word address |
| r_busy | input | 1 | Right busy from the arbiter |
| l_irq_n | output | 1 | Left port interrupt, active low |
| r_irq_n | output | 1 | Right port interrupt, active low |

## Verification
The hardest case to produce is a raise and a clear of the same interrupt landing on one edge. This needs the writer and the owner to target the same mailbox in the same cycle, one writing and one reading, with both busy inputs low. The stimulus drives that pair in one cycle, once with the interrupt already asserted and once with it clear. The busy-gated and `oe`-less owner reads are placed between a raise and a real clear, so a wrongly gated clear shows up as an early return to 1. A reference model in the bench checks both outputs on every clock.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic {
        SIDE_L = 1'b0,
        SIDE_R = 1'b1
    } side_e;

    typedef struct packed {
        logic sel;
        logic wr;
        logic oe;
        logic busy;
    } port_ctl_t;

    typedef struct packed {
        logic set;
        logic clr;
    } flag_evt_t;

    // raise has priority over acknowledge
    function automatic logic flag_next(input logic cur, input flag_evt_t e);
        if (e.set)      return 1'b1;
        else if (e.clr) return 1'b0;
        else            return cur;
    endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int AW = 12,
    parameter logic [AW-1:0] OWN_ADDR  = '1,
    parameter logic [AW-1:0] PEER_ADDR = '1
) (
    input  port_ctl_t        ctl,
    input  logic [AW-1:0]    addr,
    output logic             raise_peer,
    output logic             ack_own
);
    logic live;
    logic is_rd;

    always_comb begin
        live       = ctl.sel && !ctl.busy;
        is_rd      = !ctl.wr && ctl.oe;
        raise_peer = live && ctl.wr && (addr == PEER_ADDR);
        ack_own    = live && is_rd  && (addr == OWN_ADDR);
    end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag
    import mbx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_evt_t evt,
    output logic      irq_n
);
    logic pend;

    always_ff @(posedge clk) begin
        if (rst) pend <= 1'b0;
        else     pend <= flag_next(pend, evt);
    end

    assign irq_n = ~pend;
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
    import mbx_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          l_sel,
    input  logic          l_wr,
    input  logic          l_oe,
    input  logic [AW-1:0] l_addr,
    input  logic          l_busy,
    input  logic          r_sel,
    input  logic          r_wr,
    input  logic          r_oe,
    input  logic [AW-1:0] r_addr,
    input  logic          r_busy,
    output logic          l_irq_n,
    output logic          r_irq_n
);
    localparam logic [AW-1:0] BOX_R = '1;
    localparam logic [AW-1:0] BOX_L = BOX_R - 1'b1;
    localparam int NSIDE = 2;

    port_ctl_t     ctl   [NSIDE];
    logic [AW-1:0] addr  [NSIDE];
    logic          raise [NSIDE];
    logic          ack   [NSIDE];
    flag_evt_t     evt   [NSIDE];
    logic          irq_n [NSIDE];

    always_comb begin
        ctl[SIDE_L]  = '{sel: l_sel, wr: l_wr, oe: l_oe, busy: l_busy};
        ctl[SIDE_R]  = '{sel: r_sel, wr: r_wr, oe: r_oe, busy: r_busy};
        addr[SIDE_L] = l_addr;
        addr[SIDE_R] = r_addr;
    end

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        localparam logic [AW-1:0] OWN  = (s == 1) ? BOX_R : BOX_L;
        localparam logic [AW-1:0] PEER = (s == 1) ? BOX_L : BOX_R;

        mbx_port_decode #(.AW(AW), .OWN_ADDR(OWN), .PEER_ADDR(PEER)) u_dec (
            .ctl        (ctl[s]),
            .addr       (addr[s]),
            .raise_peer (raise[s]),
            .ack_own    (ack[s])
        );

        // own flag is raised by the opposite port, acknowledged by this port
        assign evt[s] = '{set: raise[NSIDE-1-s], clr: ack[s]};

        mbx_flag u_flag (
            .clk   (clk),
            .rst   (rst),
            .evt   (evt[s]),
            .irq_n (irq_n[s])
        );
    end

    assign l_irq_n = irq_n[SIDE_L];
    assign r_irq_n = irq_n[SIDE_R];
endmodule

// File: rtl/mbx_irq_ctrl_chk.sv
module mbx_irq_ctrl_chk #(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          l_sel,
    input logic          l_wr,
    input logic          l_oe,
    input logic [AW-1:0] l_addr,
    input logic          l_busy,
    input logic          r_sel,
    input logic          r_wr,
    input logic          r_oe,
    input logic [AW-1:0] r_addr,
    input logic          r_busy,
    input logic          l_irq_n,
    input logic          r_irq_n
);
    localparam logic [AW-1:0] TOP  = '1;
    localparam logic [AW-1:0] NEXT = TOP - 1'b1;

    logic wr_to_r, wr_to_l, rd_own_r, rd_own_l;
    assign wr_to_r  = l_sel && l_wr && !l_busy && (l_addr == TOP);
    assign wr_to_l  = r_sel && r_wr && !r_busy && (r_addr == NEXT);
    assign rd_own_r = r_sel && !r_wr && r_oe && !r_busy && (r_addr == TOP);
    assign rd_own_l = l_sel && !l_wr && l_oe && !l_busy && (l_addr == NEXT);

    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> (l_irq_n && r_irq_n));

    p_set_right_r2: assert property (@(posedge clk) disable iff (rst)
        wr_to_r |=> !r_irq_n);

    p_set_left_r3: assert property (@(posedge clk) disable iff (rst)
        wr_to_l |=> !l_irq_n);

    p_clear_right_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_own_r && !wr_to_r) |=> r_irq_n);

    p_clear_left_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_own_l && !wr_to_l) |=> l_irq_n);

    // R6/R10: interrupt only falls after a qualified raising write
    p_fall_cause_r_r6: assert property (@(posedge clk) disable iff (rst)
        ($fell(r_irq_n) && !$past(rst)) |-> $past(wr_to_r));

    p_fall_cause_l_r6: assert property (@(posedge clk) disable iff (rst)
        ($fell(l_irq_n) && !$past(rst)) |-> $past(wr_to_l));

    // R5/R7/R9: interrupt only returns high after a qualified owner read
    p_rise_cause_r_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(r_irq_n) && !$past(rst)) |-> $past(rd_own_r));

    p_rise_cause_l_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(l_irq_n) && !$past(rst)) |-> $past(rd_own_l));

    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_to_r && rd_own_r) |=> !r_irq_n);
endmodule

bind mbx_irq_ctrl mbx_irq_ctrl_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst),
    .l_sel(l_sel), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr), .l_busy(l_busy),
    .r_sel(r_sel), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr), .r_busy(r_busy),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
);

// File: tb/mbx_irq_ctrl_test.sv
`timescale 1ns/1ps
module mbx_irq_ctrl_test;
    localparam int AW = 12;
    localparam logic [AW-1:0] TOP  = '1;
    localparam logic [AW-1:0] NEXT = TOP - 1'b1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic l_sel = 0, l_wr = 0, l_oe = 0, l_busy = 0;
    logic r_sel = 0, r_wr = 0, r_oe = 0, r_busy = 0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic l_irq_n, r_irq_n;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string tag = "R1";

    // reference model: pending bits, 1 = interrupt asserted
    bit m_l = 0, m_r = 0;

    always #2 clk = ~clk;

    mbx_irq_ctrl #(.AW(AW)) uut (
        .clk(clk), .rst(rst),
        .l_sel(l_sel), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr), .l_busy(l_busy),
        .r_sel(r_sel), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr), .r_busy(r_busy),
        .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
    );

    always @(posedge clk) begin
        bit up_r, up_l, dn_r, dn_l;
        up_r = l_sel && l_wr && !l_busy && l_addr == TOP;
        up_l = r_sel && r_wr && !r_busy && r_addr == NEXT;
        dn_r = r_sel && !r_wr && r_oe && !r_busy && r_addr == TOP;
        dn_l = l_sel && !l_wr && l_oe && !l_busy && l_addr == NEXT;
        if (rst) begin
            m_l = 0; m_r = 0;
        end else begin
            if (up_r) m_r = 1; else if (dn_r) m_r = 0;
            if (up_l) m_l = 1; else if (dn_l) m_l = 0;
        end
    end

    task automatic chk(string req, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic idle();
        l_sel = 0; l_wr = 0; l_oe = 0; l_busy = 0; l_addr = '0;
        r_sel = 0; r_wr = 0; r_oe = 0; r_busy = 0; r_addr = '0;
    endtask

    // one clock; compare with model just after the edge
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        chk({tag, " model l"}, l_irq_n, ~m_l);
        chk({tag, " model r"}, r_irq_n, ~m_r);
    endtask

    task automatic lacc(logic w, logic oe, logic busy, logic [AW-1:0] a);
        l_sel = 1; l_wr = w; l_oe = oe; l_busy = busy; l_addr = a;
    endtask

    task automatic racc(logic w, logic oe, logic busy, logic [AW-1:0] a);
        r_sel = 1; r_wr = w; r_oe = oe; r_busy = busy; r_addr = a;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle();
        @(negedge clk);
        chk("R1 reset l", l_irq_n, 1'b1);
        chk("R1 reset r", r_irq_n, 1'b1);
        cyc();
        rst = 0;
        cyc();
        chk("R1 after reset l", l_irq_n, 1'b1);
        chk("R1 after reset r", r_irq_n, 1'b1);

        tag = "R2"; lacc(1, 0, 0, TOP); cyc(); idle();
        chk("R2 right raised", r_irq_n, 1'b0);
        chk("R2 left untouched", l_irq_n, 1'b1);

        tag = "R5"; lacc(0, 1, 0, TOP); cyc(); idle();
        chk("R5 peer read keeps right", r_irq_n, 1'b0);

        tag = "R4"; racc(0, 0, 0, TOP); cyc(); idle();
        chk("R4 read without oe keeps right", r_irq_n, 1'b0);

        tag = "R7"; racc(0, 1, 1, TOP); cyc(); idle();
        chk("R7 busy owner read keeps right", r_irq_n, 1'b0);

        tag = "R9"; racc(0, 1, 0, TOP); r_sel = 0; cyc(); idle();
        chk("R9 deselected read keeps right", r_irq_n, 1'b0);

        tag = "R4"; racc(0, 1, 0, TOP); cyc(); idle();
        chk("R4 owner read clears right", r_irq_n, 1'b1);

        tag = "R3"; racc(1, 0, 0, NEXT); cyc(); idle();
        chk("R3 left raised", l_irq_n, 1'b0);
        chk("R3 right untouched", r_irq_n, 1'b1);

        tag = "R5"; racc(0, 1, 0, NEXT); cyc(); idle();
        chk("R5 peer read keeps left", l_irq_n, 1'b0);

        tag = "R7"; lacc(0, 1, 1, NEXT); cyc(); idle();
        chk("R7 busy owner read keeps left", l_irq_n, 1'b0);

        tag = "R4"; lacc(0, 1, 0, NEXT); cyc(); idle();
        chk("R4 owner read clears left", l_irq_n, 1'b1);

        tag = "R6"; lacc(1, 0, 1, TOP); racc(1, 0, 1, NEXT); cyc(); idle();
        chk("R6 busy writer no raise right", r_irq_n, 1'b1);
        chk("R6 busy writer no raise left", l_irq_n, 1'b1);

        tag = "R9"; lacc(1, 0, 0, TOP); l_sel = 0; racc(1, 0, 0, NEXT); r_sel = 0;
        cyc(); idle();
        chk("R9 deselected write right", r_irq_n, 1'b1);
        chk("R9 deselected write left", l_irq_n, 1'b1);

        tag = "R10"; lacc(1, 0, 0, NEXT); racc(1, 0, 0, TOP); cyc(); idle();
        chk("R10 own mailbox write right", r_irq_n, 1'b1);
        chk("R10 own mailbox write left", l_irq_n, 1'b1);
        lacc(1, 0, 0, TOP - 2); racc(1, 0, 0, '0); cyc(); idle();
        chk("R10 other address right", r_irq_n, 1'b1);
        chk("R10 other address left", l_irq_n, 1'b1);

        tag = "R8"; lacc(1, 0, 0, TOP); racc(0, 1, 0, TOP); cyc(); idle();
        chk("R8 raise beats clear from idle", r_irq_n, 1'b0);
        lacc(1, 0, 0, TOP); racc(0, 1, 0, TOP); cyc(); idle();
        chk("R8 raise beats clear when pending", r_irq_n, 1'b0);
        racc(1, 0, 0, NEXT); lacc(0, 1, 0, NEXT); cyc(); idle();
        chk("R8 left raise beats clear", l_irq_n, 1'b0);

        // mixed traffic against the model
        tag = "R2 R3 R4 mix";
        for (int i = 0; i < 400; i++) begin
            logic [7:0] h;
            h = 8'(i * 37 + 11);
            l_sel = h[0]; l_wr = h[1]; l_oe = h[2]; l_busy = h[3] & h[5];
            r_sel = h[4]; r_wr = h[6]; r_oe = h[7]; r_busy = h[2] & h[3];
            l_addr = h[5] ? TOP : (h[6] ? NEXT : AW'(h));
            r_addr = h[1] ? NEXT : (h[0] ? TOP : AW'(h ^ 8'h5a));
            cyc();
        end
        idle();
        tag = "R1 end"; rst = 1; cyc(); rst = 0;
        chk("R1 re-reset l", l_irq_n, 1'b1);
        chk("R1 re-reset r", r_irq_n, 1'b1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule